// File: doc/BRIEF.md
# Power-Down Wake-Up Request Controller

This block decides when a system that has gone to sleep should be brought back up. It runs entirely on the crystal clock and watches two wake sources. The first is a vector of event flags from a general-purpose I/O unit, which the block merges into one line by a logical OR. The second is one dedicated external wake pin. The pin is asynchronous, so it passes through a synchronizer and must then be seen high for a qualification window of at least one full crystal cycle.

A two-bit enable register gates each source on its own. Software first sets the enables. It then pulses the power-down entry input. If the synchronized wake pin is low at that moment, the block arms. If the pin is already high, the block refuses the entry and raises an error flag. While armed, the first enabled source that fires raises a wake-up request. That request holds as a level until the processor pulses acknowledge, and the block then returns to the awake state.

All pins are plain control and status levels. No data stream crosses this block, so no valid/ready handshake is used.

Top module: `wake_ctrl`

## Requirements
- R1: After reset the enable register reads 0. A write with `ctrl_wr` high loads `ctrl_wdata` into `ctrl_en`, and the new value is visible after that clock edge. Bit 0 enables the GPIO source and bit 1 enables the wake pin.
- R2: A `pd_enter` pulse in the awake state, with the synchronized pin low, sets `pd_armed` and clears `pd_err` at the next edge.
- R3: While armed with bit 0 set, a GPIO event flag that is high at one rising edge raises `wake_req` at the second rising edge, counting that edge as the first.
- R4: While armed with bit 1 set, a wake pin that is high across a rising edge raises `wake_req` after the fourth edge, counting the first edge that sees it high. A pulse that spans no rising edge is ignored.
- R5: A source whose enable bit is clear never raises `wake_req`. With both bits clear, no request is ever generated.
- R6: Once raised, `wake_req` stays high for as long as `wake_ack` is low.
- R7: A `wake_ack` pulse during a request clears `wake_req` at the next edge and returns the block to the awake state. An acknowledge given while armed changes nothing.
- R8: A `pd_enter` pulse in the awake state while the synchronized pin is high sets `pd_err` and leaves `pd_armed` low.
- R9: While awake, neither source raises `wake_req`, even when enabled.
- R10: The GPIO source is the OR of every bit of `gpio_evt`, so any single bit alone can wake the system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_evt | input | N_GPIO | GPIO event flags, crystal domain |
| wake_pin | input | 1 | Dedicated external wake pin, asynchronous |
| ctrl_wr | input | 1 | Enable register write strobe |
| ctrl_wdata | input | 2 | Enable register write data |
| ctrl_en | output | 2 | Enable register contents |
| pd_enter | input | 1 | Power-down entry request pulse |
| wake_ack | input | 1 | Processor acknowledge pulse |
| wake_req | output | 1 | Sticky wake-up request |
| pd_armed | output | 1 | Block is armed, system asleep |
| pd_err | output | 1 | Last entry was refused because the pin was high |

## Verification
The assertions assume several things about the inputs. `pd_enter` and `wake_ack` are single-cycle pulses. `gpio_evt` is already synchronous to the crystal clock. `wake_pin` is treated as asynchronous, and the checks observe it only after the synchronizer. The bench drives every input on the falling edge, so each input is stable at the rising edge. The one exception is the deliberate sub-cycle pin glitch, which rises and falls between two rising edges to show that a pin level spanning no edge is never qualified. Between scenarios the bench drops the pin and lets the synchronizer settle before the next entry request. This keeps the illegal-entry check from firing on a stale pin level.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int CTRL_W      = 2;
  localparam int EN_GPIO_BIT = 0;
  localparam int EN_PIN_BIT  = 1;

  typedef enum logic [1:0] {
    WK_AWAKE  = 2'd0,
    WK_ARMED  = 2'd1,
    WK_WAKING = 2'd2
  } wk_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wk_pin_qual.sv
module wk_pin_qual #(
  parameter int QUAL_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic pin_qual
);
  localparam int CW = (QUAL_CYC < 1) ? 1 : $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYC);

  logic [CW-1:0] hi_cnt;

  // count consecutive high samples, saturating at the window length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= '0;
    else if (!pin_s)       hi_cnt <= '0;
    else if (hi_cnt != QMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  assign pin_qual = (hi_cnt == QMAX) && (QUAL_CYC > 0);

  // R4: qualification only ever follows a sampled high pin
  p_qual_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_qual) |-> $past(pin_s));
endmodule

// File: rtl/wk_gpio_merge.sv
module wk_gpio_merge #(
  parameter int N_GPIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] gpio_evt,
  output logic              gpio_any
);
  // R10: any single flag is enough
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpio_any <= 1'b0;
    else        gpio_any <= |gpio_evt;
  end
endmodule

// File: rtl/wk_seq.sv
module wk_seq
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] en,
  input  logic              gpio_any,
  input  logic              pin_s,
  input  logic              pin_qual,
  input  logic              pd_enter,
  input  logic              wake_ack,
  output logic              wake_req,
  output logic              pd_armed,
  output logic              pd_err
);
  wk_state_e state, state_nx;
  logic      err_nx;
  logic      src_hit;

  assign src_hit = (en[EN_GPIO_BIT] && gpio_any) || (en[EN_PIN_BIT] && pin_qual);

  always_comb begin
    state_nx = state;
    err_nx   = pd_err;
    unique case (state)
      WK_AWAKE: begin
        if (pd_enter) begin
          if (pin_s) begin
            err_nx = 1'b1;
          end else begin
            err_nx   = 1'b0;
            state_nx = WK_ARMED;
          end
        end
      end
      WK_ARMED: begin
        if (src_hit) state_nx = WK_WAKING;
      end
      WK_WAKING: begin
        if (wake_ack) state_nx = WK_AWAKE;
      end
      default: state_nx = WK_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WK_AWAKE;
      pd_err <= 1'b0;
    end else begin
      state  <= state_nx;
      pd_err <= err_nx;
    end
  end

  assign wake_req = (state == WK_WAKING);
  assign pd_armed = (state == WK_ARMED);

  // R2: a clean entry arms and clears the error
  p_clean_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_AWAKE && pd_enter && !pin_s) |=> (pd_armed && !pd_err));
  // R3: enabled GPIO source wakes
  p_gpio_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_armed && en[EN_GPIO_BIT] && gpio_any) |=> wake_req);
  // R4: enabled pin source wakes
  p_pin_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_armed && en[EN_PIN_BIT] && pin_qual) |=> wake_req);
  // R5: no enables, no request
  p_no_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_armed && en == '0) |=> !wake_req);
  // R6: request is sticky
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack) |=> wake_req);
  // R7: acknowledge clears and returns awake
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && wake_ack) |=> (!wake_req && !pd_armed));
  // R8: entry with the pin high is refused
  p_bad_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_AWAKE && pd_enter && pin_s) |=> (pd_err && !pd_armed));
  // R9: awake state never requests
  p_awake_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WK_AWAKE) |=> !wake_req);
  p_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_req, pd_armed}));
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int N_GPIO   = 8,
  parameter int SYNC_STG = 2,
  parameter int QUAL_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] gpio_evt,
  input  logic              wake_pin,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_en,
  input  logic              pd_enter,
  input  logic              wake_ack,
  output logic              wake_req,
  output logic              pd_armed,
  output logic              pd_err
);
  logic pin_s;
  logic pin_qual;
  logic gpio_any;

  // R1: enable register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_en <= '0;
    else if (ctrl_wr) ctrl_en <= ctrl_wdata;
  end

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_en == $past(ctrl_wdata)));
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_en));

  wk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(pin_s));

  wk_pin_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pin_qual(pin_qual));

  wk_gpio_merge #(.N_GPIO(N_GPIO)) u_gpio (
    .clk(clk), .rst_n(rst_n), .gpio_evt(gpio_evt), .gpio_any(gpio_any));

  wk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .gpio_any(gpio_any),
    .pin_s(pin_s), .pin_qual(pin_qual), .pd_enter(pd_enter),
    .wake_ack(wake_ack), .wake_req(wake_req), .pd_armed(pd_armed),
    .pd_err(pd_err));
endmodule

// File: tb/tb_wake_ctrl.sv
module tb_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG-1:0] gpio_evt = '0;
  logic          wake_pin = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic [1:0]    ctrl_wdata = '0;
  logic [1:0]    ctrl_en;
  logic          pd_enter = 1'b0;
  logic          wake_ack = 1'b0;
  logic          wake_req, pd_armed, pd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctrl #(.N_GPIO(NG)) dut (
    .clk(clk), .rst_n(rst_n), .gpio_evt(gpio_evt), .wake_pin(wake_pin),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_en(ctrl_en),
    .pd_enter(pd_enter), .wake_ack(wake_ack), .wake_req(wake_req),
    .pd_armed(pd_armed), .pd_err(pd_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [1:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    cyc(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic enter_pd();
    pd_enter = 1'b1;
    cyc(1);
    pd_enter = 1'b0;
  endtask

  task automatic ack();
    wake_ack = 1'b1;
    cyc(1);
    wake_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(ctrl_en == 2'b00, "R1 reset enables", ctrl_en, 0);
    chk(!wake_req && !pd_armed && !pd_err, "R1 reset outputs",
        {wake_req, pd_armed, pd_err}, 0);
  endtask

  task automatic t_ctrl();
    wr_en(2'b10);
    chk(ctrl_en == 2'b10, "R1 write", ctrl_en, 2);
    cyc(2);
    chk(ctrl_en == 2'b10, "R1 hold", ctrl_en, 2);
    wr_en(2'b01);
    chk(ctrl_en == 2'b01, "R1 rewrite", ctrl_en, 1);
  endtask

  task automatic t_awake_quiet();
    wr_en(2'b11);
    gpio_evt = 8'h01;
    cyc(4);
    gpio_evt = '0;
    chk(!wake_req, "R9 gpio while awake", wake_req, 0);
  endtask

  task automatic t_gpio_wake(input int bitn);
    wr_en(2'b01);
    enter_pd();
    chk(pd_armed, "R2 armed", pd_armed, 1);
    gpio_evt = NG'(1) << bitn;
    cyc(1);
    gpio_evt = '0;
    chk(!wake_req, "R3 not yet", wake_req, 0);
    cyc(1);
    chk(wake_req, "R10 R3 gpio bit wakes", wake_req, 1);
    cyc(5);
    chk(wake_req, "R6 sticky", wake_req, 1);
    ack();
    chk(!wake_req && !pd_armed, "R7 ack clears", wake_req, 0);
  endtask

  task automatic t_pin_wake();
    wr_en(2'b10);
    enter_pd();
    wake_pin = 1'b1;
    cyc(3);
    chk(!wake_req, "R4 pin before qual", wake_req, 0);
    cyc(1);
    chk(wake_req, "R4 pin wakes", wake_req, 1);
    ack();
    chk(!wake_req, "R7 ack after pin", wake_req, 0);
    wake_pin = 1'b0;
    cyc(4);
  endtask

  task automatic t_pin_glitch();
    wr_en(2'b10);
    enter_pd();
    wake_pin = 1'b1;
    #1 wake_pin = 1'b0;
    cyc(6);
    chk(!wake_req && pd_armed, "R4 sub-cycle glitch ignored", wake_req, 0);
    ack();
    chk(pd_armed, "R7 ack while armed ignored", pd_armed, 1);
  endtask

  task automatic t_disabled();
    // still armed, pin-only enable: GPIO must not wake
    gpio_evt = 8'h80;
    cyc(4);
    gpio_evt = '0;
    chk(!wake_req, "R5 gpio disabled", wake_req, 0);
    wr_en(2'b00);
    gpio_evt = 8'hFF;
    wake_pin = 1'b1;
    cyc(6);
    chk(!wake_req && pd_armed, "R5 both disabled", wake_req, 0);
    gpio_evt = '0;
    wake_pin = 1'b0;
    cyc(4);
    wr_en(2'b01);
    gpio_evt = 8'h10;
    cyc(2);
    gpio_evt = '0;
    chk(wake_req, "R3 wake after enable", wake_req, 1);
    ack();
  endtask

  task automatic t_bad_entry();
    wake_pin = 1'b1;
    cyc(3);
    enter_pd();
    chk(pd_err && !pd_armed, "R8 refused entry", {pd_err, pd_armed}, 2);
    wake_pin = 1'b0;
    cyc(4);
    chk(pd_err, "R8 error sticky", pd_err, 1);
    enter_pd();
    chk(pd_armed && !pd_err, "R2 clean entry clears error", {pd_err, pd_armed}, 1);
    gpio_evt = 8'h04;
    cyc(2);
    gpio_evt = '0;
    ack();
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_ctrl();
    t_awake_quiet();
    t_gpio_wake(0);
    t_gpio_wake(5);
    t_gpio_wake(NG-1);
    t_pin_wake();
    t_pin_glitch();
    t_disabled();
    t_bad_entry();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule